// File: doc/BRIEF.md
# Two-Channel Credit Flow Controller for a Switch Link

This block sits on the transmit side of a switch-to-switch link that carries two virtual channels. It tracks how many flit buffer slots are free at the far end for each channel. It lets a flit of a channel onto the link only when that channel has a free slot. It also applies a cut-through admission rule to packet heads, so a packet starts only when the far end can hold all of it. Credits come back from the receiver as pulses that name a channel and a count. The serial transceiver, framing and CRC are outside the block.

Each channel has its own 8-bit counter, a programmed maximum, which is also its reset value, and a programmed low-water threshold. When both channels have a flit ready, channel 1 normally goes first. Channel 0 wins only when channel 1 has dropped below its threshold while channel 0 is still above its own. The upstream side is one valid/ready pair per channel. The downstream side is a single valid/ready stream that carries data, byte enables, the channel number and packet delimiters. There is no buffering: handshakes pass straight through in the same cycle.

Top module: `vc_credit_tx`

## Requirements
- R1: While reset is held, each channel's credit count loads its programmed maximum (`cfg_max0`/`cfg_max1`), and `err_ovf` reads 0.
- R2: A flit accepted on a channel (`up_valid` and `up_ready` both high for that channel) with no credit return to that channel lowers that channel's credit count by exactly one on the next cycle.
- R3: A channel whose credit count is 0 gets no `up_ready`, and none of its flits appear downstream.
- R4: A head flit (`up_head` high) carries the packet length in flits in data bits [3:0] of its channel's lane. It is forwarded only when the channel's credit count is at least that length and non-zero.
- R5: A return pulse (`ret_valid`, channel `ret_vc`, count `ret_cnt` with value 1 to 4) adds the count to the named channel on the next cycle. A send and a return on the same channel in the same cycle give the net of the two.
- R6: A return that would lift a count above its programmed maximum leaves the count at the maximum, and the channel's bit of `err_ovf` is high for the following cycle only.
- R7: `low[v]` is high exactly when channel v's credit count is strictly below its threshold (`cfg_thr0`/`cfg_thr1`). A count equal to the threshold is not low.
- R8: When both channels can send, channel 1 is granted (`dn_vc` = 1), unless R9 applies.
- R9: When both channels can send, channel 1 is low and channel 0's count is strictly above its own threshold, channel 0 is granted.
- R10: The downstream side presents the granted channel's data, byte enables, head and last flags, with `dn_vc` set to the channel number. Only that channel's `up_ready` follows `dn_ready`. While `dn_ready` is low, no credit is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_max0 | input | CW | Channel 0 maximum and reset credit count |
| cfg_max1 | input | CW | Channel 1 maximum and reset credit count |
| cfg_thr0 | input | CW | Channel 0 low-water threshold |
| cfg_thr1 | input | CW | Channel 1 low-water threshold |
| up_valid | input | 2 | Per-channel flit valid |
| up_ready | output | 2 | Per-channel flit accepted |
| up_data | input | 2*DW | Per-channel data lanes, channel 0 in the low lane |
| up_be | input | 2*DW/8 | Per-channel byte enables |
| up_head | input | 2 | Per-channel head-flit flag |
| up_last | input | 2 | Per-channel last-flit flag |
| dn_valid | output | 1 | Link flit valid |
| dn_ready | input | 1 | Link accepts flit |
| dn_data | output | DW | Link data |
| dn_be | output | DW/8 | Link byte enables |
| dn_vc | output | 1 | Channel of the link flit |
| dn_head | output | 1 | Link head-flit flag |
| dn_last | output | 1 | Link last-flit flag |
| ret_valid | input | 1 | Credit return pulse |
| ret_vc | input | 1 | Channel receiving the return |
| ret_cnt | input | 3 | Number of credits returned (1 to 4) |
| cred_lvl | output | 2*CW | Credit counts, channel 0 in the low byte |
| low | output | 2 | Per-channel near-empty flag |
| err_ovf | output | 2 | Per-channel overflow pulse |

## Verification
Grant, `up_ready`, the downstream fields and `low` are combinational. The bench drives on the falling edge and checks them one time unit later, before the next rising edge. Credit counts and `err_ovf` are single registers, so their effect is due one rising edge after the stimulus. The bench checks them at the falling edge that follows that rising edge, and checks `err_ovf` again one cycle later to confirm it has cleared.

// File: rtl/vc_credit_tx.sv
module vc_credit_tx #(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     cfg_max0,
  input  logic [CW-1:0]     cfg_max1,
  input  logic [CW-1:0]     cfg_thr0,
  input  logic [CW-1:0]     cfg_thr1,
  input  logic [1:0]        up_valid,
  output logic [1:0]        up_ready,
  input  logic [2*DW-1:0]   up_data,
  input  logic [2*DW/8-1:0] up_be,
  input  logic [1:0]        up_head,
  input  logic [1:0]        up_last,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DW-1:0]     dn_data,
  output logic [DW/8-1:0]   dn_be,
  output logic              dn_vc,
  output logic              dn_head,
  output logic              dn_last,
  input  logic              ret_valid,
  input  logic              ret_vc,
  input  logic [2:0]        ret_cnt,
  output logic [2*CW-1:0]   cred_lvl,
  output logic [1:0]        low,
  output logic [1:0]        err_ovf
);
  localparam int BW = DW / 8;

  logic [CW-1:0] cred_q [2];
  logic [1:0]    elig;
  logic          prefer0;

  for (genvar v = 0; v < 2; v++) begin : g_vc
    logic [CW-1:0] mx, thr;
    logic [3:0]    len;
    logic          take;
    logic [2:0]    add;
    logic [CW+1:0] sum;

    assign mx   = (v == 1) ? cfg_max1 : cfg_max0;
    assign thr  = (v == 1) ? cfg_thr1 : cfg_thr0;
    assign len  = up_data[v*DW +: 4];
    assign take = up_valid[v] & up_ready[v];
    assign add  = (ret_valid && ret_vc == 1'(v)) ? ret_cnt : 3'd0;
    assign sum  = {2'b00, cred_q[v]} - (CW+2)'(take) + (CW+2)'(add);

    assign elig[v] = up_valid[v] && cred_q[v] != '0 &&
                     (!up_head[v] || cred_q[v] >= CW'(len));
    assign low[v]  = cred_q[v] < thr;
    assign cred_lvl[v*CW +: CW] = cred_q[v];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cred_q[v]  <= mx;
        err_ovf[v] <= 1'b0;
      end else if (sum > {2'b00, mx}) begin
        cred_q[v]  <= mx;
        err_ovf[v] <= 1'b1;
      end else begin
        cred_q[v]  <= sum[CW-1:0];
        err_ovf[v] <= 1'b0;
      end
    end

    AST_SEND_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid[v] && up_ready[v] && !(ret_valid && ret_vc == 1'(v)))
      |=> cred_q[v] == $past(cred_q[v]) - 1'b1); // R2
    AST_NO_EMPTY_SEND: assert property (@(posedge clk) disable iff (!rst_n)
      up_ready[v] |-> cred_q[v] != '0); // R3
    AST_HEAD_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      (up_ready[v] && up_head[v]) |-> cred_q[v] >= CW'(up_data[v*DW +: 4])); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cred_q[v] <= mx); // R6
  end

  assign prefer0  = low[1] && (cred_q[0] > cfg_thr0);
  assign dn_valid = |elig;
  assign dn_vc    = (&elig) ? !prefer0 : elig[1];
  assign dn_data  = dn_vc ? up_data[DW +: DW] : up_data[0 +: DW];
  assign dn_be    = dn_vc ? up_be[BW +: BW]   : up_be[0 +: BW];
  assign dn_head  = up_head[dn_vc];
  assign dn_last  = up_last[dn_vc];
  assign up_ready = {dn_valid && dn_ready && dn_vc, dn_valid && dn_ready && !dn_vc};

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(up_ready)); // R10
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!dn_ready && !ret_valid) |=> $stable(cred_lvl)); // R10
endmodule

// File: tb/vc_credit_tx_tb.sv
module vc_credit_tx_tb;
  localparam int DW = 32;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] cfg_max0 = 8'd10, cfg_max1 = 8'd6, cfg_thr0 = 8'd3, cfg_thr1 = 8'd2;
  logic [1:0] up_valid = 0, up_ready, up_head = 0, up_last = 0;
  logic [2*DW-1:0] up_data = 0;
  logic [2*DW/8-1:0] up_be = 0;
  logic dn_valid, dn_ready = 1, dn_vc, dn_head, dn_last;
  logic [DW-1:0] dn_data;
  logic [DW/8-1:0] dn_be;
  logic ret_valid = 0, ret_vc = 0;
  logic [2:0] ret_cnt = 0;
  logic [2*CW-1:0] cred_lvl;
  logic [1:0] low, err_ovf;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vc_credit_tx #(.DW(DW), .CW(CW)) u_dut (.*);

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic int c0(); return int'(cred_lvl[7:0]); endfunction
  function automatic int c1(); return int'(cred_lvl[15:8]); endfunction

  task automatic t_reset();
    chk("R1 cred0", c0(), 10);
    chk("R1 cred1", c1(), 6);
    chk("R1 err", int'(err_ovf), 0);
    chk("R7 low at reset", int'(low), 0);
  endtask

  task automatic t_prio();
    up_data = {32'hB1B1_0000, 32'hA0A0_0000};
    up_be = 8'h3C; up_valid = 2'b11; up_last = 2'b10;
    #1;
    chk("R8 vc1 wins", int'(dn_vc), 1);
    chk("R10 ready", int'(up_ready), 2);
    chk("R10 data", int'(dn_data == 32'hB1B1_0000), 1);
    chk("R10 be", int'(dn_be), 3);
    chk("R10 last", int'(dn_last), 1);
    step();
    up_valid = 0; up_last = 0;
    chk("R2 cred1 dec", c1(), 5);
    chk("R2 cred0 kept", c0(), 10);
  endtask

  task automatic t_stall();
    dn_ready = 0; up_valid = 2'b11;
    #1 chk("R10 no ready", int'(up_ready), 0);
    step();
    chk("R10 stall cred1", c1(), 5);
    chk("R10 stall cred0", c0(), 10);
    dn_ready = 1; up_valid = 0;
  endtask

  task automatic t_except();
    up_valid = 2'b10;
    for (int i = 0; i < 3; i++) step();
    chk("R7 equal not low", int'(low), 0);
    step();
    up_valid = 0;
    chk("R7 low set", int'(low), 2);
    up_valid = 2'b11;
    #1;
    chk("R9 vc0 wins", int'(dn_vc), 0);
    chk("R9 ready", int'(up_ready), 1);
    up_valid = 0;
  endtask

  task automatic t_zero();
    up_valid = 2'b10; step();
    chk("R3 cred1 empty", c1(), 0);
    #1;
    chk("R3 no valid", int'(dn_valid), 0);
    chk("R3 no ready", int'(up_ready), 0);
    step();
    chk("R3 cred1 stays", c1(), 0);
    up_valid = 0;
  endtask

  task automatic t_return();
    ret_valid = 1; ret_vc = 1; ret_cnt = 3; step();
    chk("R5 return", c1(), 3);
    ret_cnt = 2; up_valid = 2'b10; step();
    ret_valid = 0; up_valid = 0;
    chk("R5 net", c1(), 4);
  endtask

  task automatic t_head();
    up_head = 2'b10; up_valid = 2'b10;
    up_data[DW +: 4] = 4'd5;
    #1 chk("R4 head blocked", int'(dn_valid), 0);
    step();
    chk("R4 no consume", c1(), 4);
    up_data[DW +: 4] = 4'd4;
    #1;
    chk("R4 head fits", int'(dn_valid), 1);
    chk("R10 head flag", int'(dn_head), 1);
    step();
    up_valid = 0; up_head = 0;
    chk("R4 head consumed", c1(), 3);
  endtask

  task automatic t_ovf();
    ret_valid = 1; ret_vc = 1; ret_cnt = 4; step();
    ret_valid = 0;
    chk("R6 saturate", c1(), 6);
    chk("R6 err pulse", int'(err_ovf), 2);
    step();
    chk("R6 err clear", int'(err_ovf), 0);
    chk("R6 held max", c1(), 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_prio();
    t_stall();
    t_except();
    t_zero();
    t_return();
    t_head();
    t_ovf();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule